// File: doc/BRIEF.md
# Multi-mode serial clock generator

This block produces the bit-rate timing for a combined UART/SPI serial unit. It does not make derived clocks. It emits one-system-clock-wide enable pulses, `tx_tick` and `rx_tick`, so the shifters that consume them stay in the system clock domain. A prescaler counts the system clock down by (D+1), where D is the 8-bit divisor value loaded through a write strobe. The run-time configuration then chooses one of four timing schemes:

- **Asynchronous:** `rx_tick` is the oversampling enable and `tx_tick` marks each bit. The bit rate is fx/(16·(D+1)) in normal mode and fx/(8·(D+1)) in double-speed mode.
- **Synchronous or SPI master:** the block drives the serial clock pin at fx/(2·(D+1)).
- **Synchronous or SPI slave:** the block samples the pin through a synchronizer and turns its edges into ticks.

The polarity bit sets the idle level of the serial clock. The *leading* edge is the edge that leaves the idle level, and it produces `rx_tick`. The *trailing* edge is the edge that returns to the idle level, and it produces `tx_tick`.

Configuration is applied cleanly by writing the divisor. The write restarts the prescaler, the oversampling counter and the master clock phase. The serial clock pin and all control pins are plain levels. There is no streamed data interface, so no valid/ready handshake applies.

Top module: `ser_clkgen`

## Requirements
- R1: The prescaler period is D+1 system clocks, where D is the value latched by `div_wr`. The first prescaler event appears D+1 cycles after the write cycle, for every D from 0 to 255.
- R2: In asynchronous normal mode (`dbl_spd`=0), `rx_tick` pulses every D+1 cycles and `tx_tick` pulses every 16·(D+1) cycles. Every `tx_tick` coincides with an `rx_tick`.
- R3: In asynchronous double-speed mode (`dbl_spd`=1), `rx_tick` pulses every D+1 cycles and `tx_tick` pulses every 8·(D+1) cycles.
- R4: `mode_sel` is decoded as follows:
  - 2'b00: asynchronous.
  - 2'b01: synchronous.
  - 2'b11: SPI, with the same timing as synchronous.
  - 2'b10: reserved, and it behaves as asynchronous.
- R5: In synchronous or SPI mode with `master`=1, the block behaves as follows:
  - `sck_oe`=1.
  - `sck_out` starts at the `cpol` level after a divisor write and toggles every D+1 cycles, for a period of 2·(D+1).
  - `rx_tick` pulses in the cycle in which `sck_out` leaves `cpol`, and `tx_tick` pulses in the cycle in which it returns to `cpol`.
  - `rx_tick` and `tx_tick` are never high together.
- R6: In synchronous or SPI mode with `master`=0, the block behaves as follows:
  - `sck_in` passes through a two-stage synchronizer and an edge detector.
  - A pin transition that is set up before clock edge j produces a tick visible after edge j+2.
  - A transition away from `cpol` gives `rx_tick`, and a transition toward `cpol` gives `tx_tick`.
  - The pin must toggle no faster than every 2 system clocks.
- R7: Outside master synchronous operation, `sck_oe`=0 and `sck_out` equals `cpol`. In asynchronous modes `sck_in` has no effect on the ticks.
- R8: A cycle with `div_wr`=1 forces both ticks low after that edge. It also restarts the prescaler and the divider state, so the period that follows the write has full length.
- R9: Every tick is exactly one system clock wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock fx |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_wr | input | 1 | Divisor write strobe; loads `div_data` and restarts dividers |
| div_data | input | 8 | Divisor value D |
| mode_sel | input | 2 | Operating mode (00 async, 01 sync, 10 reserved/async, 11 SPI) |
| dbl_spd | input | 1 | Asynchronous double-speed select |
| master | input | 1 | 1: drive serial clock; 0: follow external serial clock |
| cpol | input | 1 | Serial clock idle level |
| sck_in | input | 1 | External serial clock pin input |
| sck_out | output | 1 | Serial clock pin output value |
| sck_oe | output | 1 | Serial clock pin output enable |
| tx_tick | output | 1 | Transmit enable pulse |
| rx_tick | output | 1 | Receive / oversampling enable pulse |

## Verification
The hardest situation to reach is slave operation at its speed limit with either polarity. The bench has to predict tick timing across the synchronizer latency. It also has to keep the pin history consistent across configuration changes, so that no stale edge leaks into the next run. The stimulus handles this in three steps:
- Before each divisor write, it holds the pin at the idle level for several cycles.
- It then toggles the pin with random half-periods, down to two cycles.
- It models the expected ticks from the pin values the bench itself applied at each edge.

Master and asynchronous runs toggle the pin at random to show that it is ignored. A divisor of 255 exercises the longest prescaler period.

// File: rtl/ser_clk_pkg.sv
package ser_clk_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_SYNC  = 2'b01,
    MODE_RSVD  = 2'b10,
    MODE_SPI   = 2'b11
  } ser_mode_e;

  // Synchronous timing applies to both the plain synchronous and SPI codes.
  function automatic logic is_sync(input logic [1:0] m);
    return (m == MODE_SYNC) || (m == MODE_SPI);
  endfunction

endpackage

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_data,
  output logic             pre_tick
);

  logic [DIV_W-1:0] bd_q;
  logic [DIV_W-1:0] cnt_q;

  // Up-counter that wraps at the latched divisor; a write restarts it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bd_q  <= '0;
      cnt_q <= '0;
    end else if (div_wr) begin
      bd_q  <= div_data;
      cnt_q <= '0;
    end else if (cnt_q == bd_q) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pre_tick = (cnt_q == bd_q) && !div_wr;

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= bd_q);

  // R8
  reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (cnt_q == '0));

endmodule

// File: rtl/sclk_async_div.sv
module sclk_async_div #(
  parameter int OVS_NORM = 16,
  parameter int OVS_DBL  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_wr,
  input  logic pre_tick,
  input  logic dbl_spd,
  output logic tx_tick,
  output logic rx_tick
);

  localparam int POST_W = $clog2(OVS_NORM);
  localparam logic [POST_W-1:0] LAST_NORM = POST_W'(OVS_NORM - 1);
  localparam logic [POST_W-1:0] LAST_DBL  = POST_W'(OVS_DBL - 1);

  logic [POST_W-1:0] post_q;
  logic [POST_W-1:0] last;
  logic              bit_end;
  logic              tx_q, rx_q;

  assign last    = dbl_spd ? LAST_DBL : LAST_NORM;
  // ">=" keeps the count legal if the speed bit changes mid-bit.
  assign bit_end = (post_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_q <= '0;
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
    end else if (div_wr) begin
      post_q <= '0;
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
    end else begin
      rx_q <= pre_tick;
      tx_q <= pre_tick && bit_end;
      if (pre_tick) post_q <= bit_end ? '0 : post_q + 1'b1;
    end
  end

  assign tx_tick = tx_q;
  assign rx_tick = rx_q;

  // R2
  tx_with_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_q |-> rx_q);

endmodule

// File: rtl/sclk_master_gen.sv
module sclk_master_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic div_wr,
  input  logic en,
  input  logic pre_tick,
  output logic phase,
  output logic tx_tick,
  output logic rx_tick
);

  logic phase_q, tx_q, rx_q;

  // Phase 0 is the idle level; leaving it is the leading edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      tx_q    <= 1'b0;
      rx_q    <= 1'b0;
    end else if (div_wr || !en) begin
      phase_q <= 1'b0;
      tx_q    <= 1'b0;
      rx_q    <= 1'b0;
    end else begin
      rx_q <= pre_tick && !phase_q;
      tx_q <= pre_tick &&  phase_q;
      if (pre_tick) phase_q <= ~phase_q;
    end
  end

  assign phase   = phase_q;
  assign tx_tick = tx_q;
  assign rx_tick = rx_q;

  // R5
  ticks_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_q && tx_q));

endmodule

// File: rtl/sclk_slave_edge.sv
module sclk_slave_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_wr,
  input  logic en,
  input  logic cpol,
  input  logic sck_in,
  output logic tx_tick,
  output logic rx_tick
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;
  logic                   chg;
  logic                   tx_q, rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], sck_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur = sync_q[SYNC_STAGES-1];
  assign chg = cur ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= 1'b0;
      rx_q <= 1'b0;
    end else if (div_wr || !en) begin
      tx_q <= 1'b0;
      rx_q <= 1'b0;
    end else begin
      rx_q <= chg && (cur != cpol);
      tx_q <= chg && (cur == cpol);
    end
  end

  assign tx_tick = tx_q;
  assign rx_tick = rx_q;

  // R9
  slave_rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_q |=> !rx_q);

  // R9
  slave_tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_q |=> !tx_q);

endmodule

// File: rtl/ser_clkgen.sv
module ser_clkgen
  import ser_clk_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int OVS_NORM    = 16,
  parameter int OVS_DBL     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_data,
  input  logic [1:0]       mode_sel,
  input  logic             dbl_spd,
  input  logic             master,
  input  logic             cpol,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_oe,
  output logic             tx_tick,
  output logic             rx_tick
);

  logic sync_mode, mst_en, slv_en;
  logic pre_tick;
  logic a_tx, a_rx, m_tx, m_rx, s_tx, s_rx;
  logic m_phase;

  assign sync_mode = is_sync(mode_sel);
  assign mst_en    = sync_mode && master;
  assign slv_en    = sync_mode && !master;

  sclk_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_data(div_data),
    .pre_tick(pre_tick)
  );

  sclk_async_div #(.OVS_NORM(OVS_NORM), .OVS_DBL(OVS_DBL)) u_async (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .pre_tick(pre_tick),
    .dbl_spd(dbl_spd), .tx_tick(a_tx), .rx_tick(a_rx)
  );

  sclk_master_gen u_mst (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .en(mst_en),
    .pre_tick(pre_tick), .phase(m_phase), .tx_tick(m_tx), .rx_tick(m_rx)
  );

  sclk_slave_edge #(.SYNC_STAGES(SYNC_STAGES)) u_slv (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .en(slv_en), .cpol(cpol),
    .sck_in(sck_in), .tx_tick(s_tx), .rx_tick(s_rx)
  );

  // Pin is driven only in master synchronous operation; idle level otherwise.
  assign sck_oe  = mst_en;
  assign sck_out = mst_en ? (m_phase ^ cpol) : cpol;

  always_comb begin
    if (mst_en) begin
      tx_tick = m_tx;
      rx_tick = m_rx;
    end else if (slv_en) begin
      tx_tick = s_tx;
      rx_tick = s_rx;
    end else begin
      tx_tick = a_tx;
      rx_tick = a_rx;
    end
  end

  // R8
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (!tx_tick && !rx_tick));

endmodule

// File: tb/test_ser_clkgen.sv
module test_ser_clkgen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       div_wr;
  logic [7:0] div_data;
  logic [1:0] mode_sel;
  logic       dbl_spd, master, cpol, sck_in;
  logic       sck_out, sck_oe, tx_tick, rx_tick;

  always #10 clk = ~clk;

  ser_clkgen i_ser_clkgen (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_data(div_data),
    .mode_sel(mode_sel), .dbl_spd(dbl_spd), .master(master), .cpol(cpol),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .tx_tick(tx_tick), .rx_tick(rx_tick)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic ph [4];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int t,
                     input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s t=%0d actual=%b expected=%b", req, what, t, act, exp);
    end
  endtask

  task automatic push();
    ph[3] = ph[2]; ph[2] = ph[1]; ph[1] = ph[0]; ph[0] = sck_in;
  endtask

  function automatic logic is_sync_m(input logic [1:0] m);
    return (m == 2'b01) || (m == 2'b11);
  endfunction

  task automatic check_at(input int t, input int bd, input string tag);
    logic e_rx, e_tx, e_oe, e_out;
    string req;
    int p, l, k;
    p = bd + 1;
    if (!is_sync_m(mode_sel)) begin
      l     = dbl_spd ? 8 : 16;
      e_rx  = (t > 0) && (t % p == 0);
      e_tx  = (t > 0) && (t % (l * p) == 0);
      e_oe  = 1'b0;
      e_out = cpol;
      req   = (mode_sel == 2'b10) ? "R4" : (dbl_spd ? "R3" : "R2");
    end else if (master) begin
      k     = t / p;
      e_rx  = (t > 0) && (t % p == 0) && (k % 2 == 1);
      e_tx  = (t > 0) && (t % p == 0) && (k % 2 == 0);
      e_oe  = 1'b1;
      e_out = cpol ^ logic'(k % 2);
      req   = "R5";
    end else begin
      e_rx  = (t > 0) && (ph[2] != ph[3]) && (ph[2] != cpol);
      e_tx  = (t > 0) && (ph[2] != ph[3]) && (ph[2] == cpol);
      e_oe  = 1'b0;
      e_out = cpol;
      req   = "R6";
    end
    if (t == 0) req = "R8";
    if (tag != "") req = tag;
    chk(req, "rx_tick", t, rx_tick, e_rx);
    chk(req, "tx_tick", t, tx_tick, e_tx);
    chk(is_sync_m(mode_sel) && master ? req : "R7", "sck_oe", t, sck_oe, e_oe);
    chk(is_sync_m(mode_sel) && master ? req : "R7", "sck_out", t, sck_out, e_out);
  endtask

  task automatic run_cfg(input logic [1:0] md, input logic db, input logic ms,
                         input logic cp, input int bd, input int ncyc,
                         input int half, input string tag);
    logic slave;
    slave = is_sync_m(md) && !ms;
    @(negedge clk);
    mode_sel = md; dbl_spd = db; master = ms; cpol = cp; sck_in = cp;
    repeat (4) begin
      @(posedge clk); push();
      @(negedge clk);
    end
    div_data = 8'(bd); div_wr = 1'b1;
    @(posedge clk); push();
    @(negedge clk); div_wr = 1'b0;
    check_at(0, bd, tag);
    for (int t = 1; t <= ncyc; t++) begin
      if (slave) begin
        if (t > 3 && (t % half) == 0) sck_in = ~sck_in;
      end else begin
        sck_in = logic'($urandom_range(0, 1));
      end
      @(posedge clk); push();
      @(negedge clk);
      check_at(t, bd, tag);
    end
  endtask

  initial begin
    void'($urandom(32'd20517));
    rst_n = 1'b0; div_wr = 1'b0; div_data = 8'd0; mode_sel = 2'b00;
    dbl_spd = 1'b0; master = 1'b0; cpol = 1'b0; sck_in = 1'b0;
    for (int i = 0; i < 4; i++) ph[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state (R7): async default, pin not driven, no ticks
    chk("R7", "reset sck_oe", 0, sck_oe, 1'b0);
    chk("R8", "reset tx_tick", 0, tx_tick, 1'b0);
    chk("R8", "reset rx_tick", 0, rx_tick, 1'b0);
    rst_n = 1'b1;

    // Directed corner cases
    run_cfg(2'b00, 1'b0, 1'b0, 1'b0, 0,   70,   2, "R1");   // smallest divisor
    run_cfg(2'b00, 1'b1, 1'b0, 1'b1, 3,   100,  2, "R3");
    run_cfg(2'b10, 1'b0, 1'b1, 1'b0, 2,   120,  2, "R4");   // reserved code -> async
    run_cfg(2'b01, 1'b0, 1'b1, 1'b0, 255, 1030, 2, "R1");   // largest divisor
    run_cfg(2'b11, 1'b0, 1'b1, 1'b1, 1,   40,   2, "R5");
    run_cfg(2'b01, 1'b0, 1'b0, 1'b0, 0,   60,   2, "R9");   // slave at speed limit
    run_cfg(2'b11, 1'b0, 1'b0, 1'b1, 4,   60,   3, "R6");
    run_cfg(2'b00, 1'b0, 1'b1, 1'b1, 1,   70,   2, "R7");   // master bit ignored in async

    // Constrained random configurations
    for (int r = 0; r < 30; r++) begin
      logic [1:0] md;
      int bd, hf;
      md = 2'($urandom_range(0, 3));
      bd = $urandom_range(0, 9);
      hf = $urandom_range(2, 6);
      run_cfg(md, logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)),
              logic'($urandom_range(0, 1)), bd, 3 * 16 * (bd + 1) + 8, hf, "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule